// File: doc/BRIEF.md
# Extension-Descriptor and Exception-PC Legalizer

This block is a small slice of a machine-mode control-register file. It holds two registers: the extension-descriptor register, which reports the native register width and the set of supported instruction extensions, and the exception program counter, which records where a trap was taken. Software writes to both registers pass through legalization rules before they are stored. The only run-time-changeable field is the compressed-instruction bit. The fetch unit also gets an alignment mask that follows that bit.

Two static configuration inputs shape the behaviour. One picks whether compressed instructions are on at reset. The other picks whether the descriptor register accepts writes at all. A trap-entry port loads the exception PC directly. It goes through the same low-bit legalization as a software write, and it wins over a software write in the same cycle.

Top module: `csr_isa_epc_legalizer`

## Requirements
- R1: After reset the descriptor read data has the width code in its two top bits (1 for 32-bit, 2 for 64-bit). Bits 0, 8, 12, 18 and 20 read 1. Bit 2 (compressed) equals `cfg_cmp_en`. All other bits read 0. The exception PC reads 0.
- R2: When `cfg_isa_wr_en` is 1, a write to address 0x301 copies data bit 2 into the compressed bit and leaves every other descriptor bit unchanged.
- R3: A write to 0x301 with data bit 2 equal to 0 is ignored when bit 1 of `next_pc` is 1.
- R4: When `cfg_isa_wr_en` is 0, writes to 0x301 are ignored and the descriptor keeps its reset value.
- R5: A write to address 0x341 stores the data with bit 0 cleared if `cfg_isa_wr_en` is 1 or the compressed bit is 1. Otherwise it stores the data with bits 1 and 0 cleared.
- R6: `pc_align_mask` is all ones while the compressed bit is 1. While the bit is 0, the mask is all ones except bit 1.
- R7: `epc_rdata` equals the stored exception PC ANDed with `pc_align_mask`.
- R8: Writes to any address other than 0x301 and 0x341 change neither register.
- R9: `trap_epc_ld` loads `trap_epc_val` into the exception PC using the R5 low-bit rule. It takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmp_en | input | 1 | Static: compressed support on at reset |
| cfg_isa_wr_en | input | 1 | Static: descriptor register accepts writes |
| wr_en | input | 1 | Software register write strobe |
| wr_addr | input | ADDR_W | Software write address |
| wr_data | input | XLEN | Software write data |
| next_pc | input | XLEN | Address of the next instruction |
| trap_epc_ld | input | 1 | Trap-entry load of the exception PC |
| trap_epc_val | input | XLEN | Exception PC value on trap entry |
| isa_rdata | output | XLEN | Descriptor read data |
| epc_rdata | output | XLEN | Masked exception PC read data |
| pc_align_mask | output | XLEN | Fetch alignment mask |

## Verification
A write or trap load is captured at the clock edge. Its effect on `isa_rdata`, `epc_rdata` and `pc_align_mask` appears on the same edge, because all three outputs are combinational from the stored state. Each check therefore drives its inputs at a falling edge, lets one rising edge pass, and samples at the next falling edge. Reset values are sampled while reset is held and after it is released. A refused or ignored write is checked by reading the unchanged register values one cycle later.

// File: rtl/csr_isa_epc_legalizer.sv
module csr_isa_epc_legalizer #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ISA_ADDR = 12'h301,
  parameter logic [ADDR_W-1:0] EPC_ADDR = 12'h341
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cmp_en,
  input  logic              cfg_isa_wr_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              trap_epc_ld,
  input  logic [XLEN-1:0]   trap_epc_val,
  output logic [XLEN-1:0]   isa_rdata,
  output logic [XLEN-1:0]   epc_rdata,
  output logic [XLEN-1:0]   pc_align_mask
);

  localparam logic [1:0] WIDTH_CODE = (XLEN == 64) ? 2'd2 : 2'd1;
  localparam int C_POS = 2;
  localparam logic [XLEN-1:0] EXT_FIXED =
    XLEN'((1 << 0) | (1 << 8) | (1 << 12) | (1 << 18) | (1 << 20));
  localparam logic [XLEN-1:0] ISA_FIXED = {WIDTH_CODE, {(XLEN-2){1'b0}}} | EXT_FIXED;

  logic            cmp_q;
  logic [XLEN-1:0] epc_q;

  wire isa_hit = wr_en && (wr_addr == ISA_ADDR);
  wire epc_hit = wr_en && (wr_addr == EPC_ADDR);

  wire isa_accept = isa_hit && cfg_isa_wr_en && !(!wr_data[C_POS] && next_pc[1]);

  wire             keep_bit1  = cfg_isa_wr_en || cmp_q;
  wire [XLEN-1:0]  low_clear  = keep_bit1 ? ~XLEN'(1) : ~XLEN'(3);
  wire [XLEN-1:0]  epc_source = trap_epc_ld ? trap_epc_val : wr_data;
  wire             epc_load   = trap_epc_ld || epc_hit;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{next_pc[XLEN-1:2], next_pc[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= cfg_cmp_en;
      epc_q <= '0;
    end else begin
      if (isa_accept) cmp_q <= wr_data[C_POS];
      if (epc_load)   epc_q <= epc_source & low_clear;
    end
  end

  assign isa_rdata     = ISA_FIXED | (XLEN'(cmp_q) << C_POS);
  assign pc_align_mask = cmp_q ? '1 : ~XLEN'(2);
  assign epc_rdata     = epc_q & pc_align_mask;

  p_set_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_hit && cfg_isa_wr_en && wr_data[C_POS]) |=> isa_rdata[C_POS]);

  p_clear_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_hit && !wr_data[C_POS] && next_pc[1]) |=> $stable(isa_rdata));

  p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_isa_wr_en |-> (isa_rdata[C_POS] == cfg_cmp_en));

  p_epc_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    epc_rdata[0] == 1'b0);

  p_mask_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    isa_rdata[C_POS] |-> (pc_align_mask == '1));

  p_trap_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_epc_ld |=> (epc_rdata[XLEN-1:2] == $past(trap_epc_val[XLEN-1:2])));

endmodule

// File: tb/csr_isa_epc_legalizer_tb.sv
`timescale 1ns/1ps
module csr_isa_epc_legalizer_tb_top;
  localparam int XLEN = 32;

  logic clk = 0, rst_n = 0, cfg_cmp_en = 1, cfg_isa_wr_en = 1;
  logic wr_en = 0, trap_epc_ld = 0;
  logic [11:0] wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0, next_pc = '0, trap_epc_val = '0;
  logic [XLEN-1:0] isa_rdata, epc_rdata, pc_align_mask;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_isa_epc_legalizer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cmp_en(cfg_cmp_en), .cfg_isa_wr_en(cfg_isa_wr_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .next_pc(next_pc),
    .trap_epc_ld(trap_epc_ld), .trap_epc_val(trap_epc_val),
    .isa_rdata(isa_rdata), .epc_rdata(epc_rdata), .pc_align_mask(pc_align_mask));

  localparam logic [XLEN-1:0] ISA_C1 = 32'h4014_1105;
  localparam logic [XLEN-1:0] ISA_C0 = 32'h4014_1101;

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic cmp, logic wren);
    @(negedge clk);
    rst_n = 0; cfg_cmp_en = cmp; cfg_isa_wr_en = wren;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write(logic [11:0] a, logic [XLEN-1:0] d, logic [XLEN-1:0] pc);
    wr_en = 1; wr_addr = a; wr_data = d; next_pc = pc;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset_state;
    do_reset(1, 1);
    check("R1", "isa reset", isa_rdata, ISA_C1);
    check("R1", "epc reset", epc_rdata, '0);
    check("R6", "mask with C=1", pc_align_mask, '1);
  endtask

  task automatic t_clear_c_and_epc;
    write(12'h301, 32'hFFFF_FFFB, 32'h100);
    check("R2", "only C cleared", isa_rdata, ISA_C0);
    check("R6", "mask with C=0", pc_align_mask, 32'hFFFF_FFFD);
    write(12'h341, 32'h1237, 32'h100);
    check("R7", "epc masked read", epc_rdata, 32'h1234);
    write(12'h301, 32'h0000_0004, 32'h102);
    check("R2", "C set", isa_rdata, ISA_C1);
    check("R5", "epc kept bit1 when writable", epc_rdata, 32'h1236);
  endtask

  task automatic t_refuse_clear;
    write(12'h301, 32'h0, 32'h102);
    check("R3", "clear refused at 2-byte pc", isa_rdata, ISA_C1);
    write(12'h301, 32'h0, 32'h104);
    check("R3", "clear accepted at 4-byte pc", isa_rdata, ISA_C0);
  endtask

  task automatic t_other_addr;
    write(12'h300, 32'h4, 32'h0);
    write(12'h342, 32'hAAAA_AAAA, 32'h0);
    check("R8", "isa untouched", isa_rdata, ISA_C0);
    check("R8", "epc untouched", epc_rdata, 32'h1234);
  endtask

  task automatic t_trap_priority;
    trap_epc_ld = 1; trap_epc_val = 32'h8887;
    write(12'h341, 32'h5555, 32'h0);
    trap_epc_ld = 0;
    write(12'h301, 32'h4, 32'h0);
    check("R9", "trap load wins", epc_rdata, 32'h8886);
  endtask

  task automatic t_locked;
    do_reset(0, 0);
    check("R1", "isa reset no C", isa_rdata, ISA_C0);
    check("R6", "mask reset no C", pc_align_mask, 32'hFFFF_FFFD);
    write(12'h301, 32'h4, 32'h0);
    check("R4", "locked set ignored", isa_rdata, ISA_C0);
    do_reset(1, 0);
    write(12'h301, 32'h0, 32'h0);
    check("R4", "locked clear ignored", isa_rdata, ISA_C1);
    write(12'h341, 32'h1237, 32'h0);
    check("R5", "epc bit0 cleared with C=1", epc_rdata, 32'h1236);
  endtask

  initial begin
    t_reset_state();
    t_clear_c_and_epc();
    t_refuse_clear();
    t_other_addr();
    t_trap_priority();
    t_locked();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule